// File: doc/BRIEF.md
# Two-Word Instruction Fetch and Decode Sequencer

This block steps through a stream of 16-bit instruction words held in a byte-addressed program memory. It keeps a 21-bit program counter that starts at zero. For every word it pulses a read strobe on the program memory port, waits one cycle for the synchronous memory to answer, and then decodes the word. Words are stored little-endian: the word at byte address A is made of the byte at A+1 (upper half) and the byte at A (lower half). The fetch address on the port is always the byte address of the lower half.

Decoded instructions become registered control pulses. Load-literal and add-literal drive an ALU command. Store-working-register drives a data RAM write. Its 8-bit file field is first mapped through the access bank: the lower half of the field reaches general RAM and the upper half reaches the special-function window at the top of the 12-bit data space. Two instructions take two words. The first is a file-to-file copy, which reads and then writes the data RAM. The second is a jump, which reloads the program counter. The second word of each starts with the prefix 1111. A word with that prefix that does not follow a matching first word does nothing.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `imem_rd`, `alu_en`, `dram_re` and `dram_we` are low. The first fetch after reset is from byte address 0.
- R2: Each fetch is a one-cycle `imem_rd` pulse. Without a jump, successive fetches use byte addresses that rise by 2 per word.
- R3: Word 0x0E_kk (load-literal) produces one `alu_en` pulse with `alu_add`=0 and `alu_k`=kk.
- R4: Word 0x0F_kk (add-literal) produces one `alu_en` pulse with `alu_add`=1 and `alu_k`=kk.
- R5: Word 0x6E_ff (store-working-register, bank bit 0) produces one `dram_we` pulse whose `dram_wdata` is the value on `w_in` when the word is decoded.
- R6: The store address is 0x000+ff when ff < 0x80 and 0xF00+ff when ff >= 0x80.
- R7: Word 0x6F_ff (bank bit 1) has no effect on the ALU or data RAM ports.
- R8: Words 0xC_sss then 0xF_ddd (copy) give a `dram_re` pulse at address sss. In the very next cycle they give a `dram_we` pulse at address ddd, with `dram_wdata` equal to `dram_rdata`. The copy raises no `alu_en`.
- R9: Words 0xEF_ll then 0xF_hhh (jump) make the next fetch come from byte address {hhh, ll, 0}.
- R10: A word with prefix 0xF that does not directly follow a copy or jump first word is a no-operation, and the fetch address still advances by 2.
- R11: If a copy or jump first word is followed by a word without prefix 0xF, the pending instruction is dropped and that word is decoded as a new instruction.
- R12: Words matching none of the above encodings have no effect on the ALU or data RAM ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 21 | Byte address of the word being fetched |
| imem_rd | output | 1 | Program memory read strobe |
| imem_data | input | 16 | Instruction word, valid the cycle after the strobe |
| w_in | input | 8 | Current working register value from the ALU |
| alu_en | output | 1 | ALU command strobe |
| alu_add | output | 1 | 1 = add literal to working register, 0 = load literal |
| alu_k | output | 8 | Literal operand |
| dram_addr | output | 12 | Data RAM address |
| dram_re | output | 1 | Data RAM read strobe |
| dram_we | output | 1 | Data RAM write strobe |
| dram_wdata | output | 8 | Data RAM write data |
| dram_rdata | input | 8 | Data RAM read data, valid the cycle after the read strobe |

## Verification
Two cases are hard to reach from the ports. One is a two-word first half followed by something other than its tail. The other is a jump whose upper address bits lie far above any real memory. The program generator places deliberately broken pairs in the instruction stream. It also puts code at a jump target whose 21-bit byte address aliases into the bench memory, so the full target is compared on `imem_addr`. A sweep of store instructions over all 256 file addresses covers both halves of the access-bank mapping. The copy sweep reads back values written earlier in the same run, including into and out of the special-function window.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    K_NOP, K_MOVL, K_ADDL, K_STW, K_CPY1, K_JMP1, K_TAIL
  } kind_t;

  typedef enum logic [1:0] {ST_REQ, ST_WAIT, ST_DEC, ST_CPW} state_t;

  typedef enum logic [1:0] {PEND_NONE, PEND_CPY, PEND_JMP} pend_t;

  localparam logic [7:0] OPC_MOVL = 8'h0E;
  localparam logic [7:0] OPC_ADDL = 8'h0F;
  localparam logic [7:0] OPC_JMP  = 8'hEF;
  localparam logic [6:0] OPC_STW  = 7'b0110111;
  localparam logic [3:0] OPC_CPY  = 4'hC;
  localparam logic [3:0] OPC_TAIL = 4'hF;
endpackage

// File: rtl/fs_decode.sv
module fs_decode
  import fs_pkg::*;
(
  input  logic [7:0] op,
  output kind_t      kind
);
  always_comb begin
    kind = K_NOP;
    if (op[7:4] == OPC_TAIL)                  kind = K_TAIL;
    else if (op == OPC_MOVL)                  kind = K_MOVL;
    else if (op == OPC_ADDL)                  kind = K_ADDL;
    else if (op[7:1] == OPC_STW && !op[0])    kind = K_STW;
    else if (op == OPC_JMP)                   kind = K_JMP1;
    else if (op[7:4] == OPC_CPY)              kind = K_CPY1;
  end
endmodule

// File: rtl/fs_bank_map.sv
module fs_bank_map #(
  parameter int FW   = 8,
  parameter int DA_W = 12
) (
  input  logic [FW-1:0]   fsel,
  output logic [DA_W-1:0] phys
);
  localparam int EXT_W = DA_W - FW;

  // lower half of the field stays low, upper half lands at the top of space
  assign phys = {{EXT_W{fsel[FW-1]}}, fsel};
endmodule

// File: rtl/fs_pc.sv
module fs_pc #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            load,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= tgt;
    else if (inc)  pc <= pc + STEP;
  end

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc[0] == 1'b0);
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fs_pkg::*;
#(
  parameter int PC_W = 21,
  parameter int IW   = 16,
  parameter int DW   = 8,
  parameter int FW   = 8,
  parameter int DA_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  output logic            imem_rd,
  input  logic [IW-1:0]   imem_data,
  input  logic [DW-1:0]   w_in,
  output logic            alu_en,
  output logic            alu_add,
  output logic [DW-1:0]   alu_k,
  output logic [DA_W-1:0] dram_addr,
  output logic            dram_re,
  output logic            dram_we,
  output logic [DW-1:0]   dram_wdata,
  input  logic [DW-1:0]   dram_rdata
);
  localparam int OP_W  = 8;
  localparam int SEC_W = IW - 4;
  localparam int JLO_W = IW - OP_W;

  state_t          st;
  pend_t           pend;
  kind_t           kind;
  logic [SEC_W-1:0] hold;
  logic [DW-1:0]   wd_q;
  logic            cp_q;
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] jmp_tgt;
  logic [DA_W-1:0] stw_phys;
  logic            dec_now, pc_load, pc_inc;

  fs_decode u_dec (.op(imem_data[IW-1 -: OP_W]), .kind(kind));

  fs_bank_map #(.FW(FW), .DA_W(DA_W)) u_map (
    .fsel(imem_data[FW-1:0]), .phys(stw_phys));

  assign dec_now = (st == ST_DEC);
  assign pc_load = dec_now && kind == K_TAIL && pend == PEND_JMP;
  assign pc_inc  = dec_now && !pc_load;
  assign jmp_tgt = PC_W'({imem_data[SEC_W-1:0], hold[JLO_W-1:0], 1'b0});

  fs_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_load), .tgt(jmp_tgt), .pc(pc));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_REQ;  pend <= PEND_NONE;  hold <= '0;
      imem_addr <= '0;  imem_rd <= 1'b0;
      alu_en <= 1'b0;  alu_add <= 1'b0;  alu_k <= '0;
      dram_addr <= '0;  dram_re <= 1'b0;  dram_we <= 1'b0;
      wd_q <= '0;  cp_q <= 1'b0;
    end else begin
      imem_rd <= 1'b0;  alu_en <= 1'b0;
      dram_re <= 1'b0;  dram_we <= 1'b0;  cp_q <= 1'b0;
      case (st)
        ST_REQ: begin
          imem_addr <= pc;
          imem_rd   <= 1'b1;
          st        <= ST_WAIT;
        end
        ST_WAIT: st <= ST_DEC;
        ST_DEC: begin
          st   <= ST_REQ;
          pend <= PEND_NONE;
          case (kind)
            K_MOVL, K_ADDL: begin
              alu_en  <= 1'b1;
              alu_add <= (kind == K_ADDL);
              alu_k   <= imem_data[DW-1:0];
            end
            K_STW: begin
              dram_addr <= stw_phys;
              dram_we   <= 1'b1;
              wd_q      <= w_in;
            end
            K_CPY1: begin
              pend <= PEND_CPY;
              hold <= imem_data[SEC_W-1:0];
            end
            K_JMP1: begin
              pend <= PEND_JMP;
              hold <= SEC_W'(imem_data[JLO_W-1:0]);
            end
            K_TAIL: begin
              if (pend == PEND_CPY) begin
                dram_addr <= hold;
                dram_re   <= 1'b1;
                hold      <= imem_data[SEC_W-1:0];
                st        <= ST_CPW;
              end
            end
            default: ;
          endcase
        end
        ST_CPW: begin
          dram_addr <= hold;
          dram_we   <= 1'b1;
          cp_q      <= 1'b1;
          st        <= ST_REQ;
        end
        default: st <= ST_REQ;
      endcase
    end
  end

  assign dram_wdata = cp_q ? dram_rdata : wd_q;

  // R2
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    imem_rd |=> !imem_rd);
  // R8
  copy_seq_chk: assert property (@(posedge clk) disable iff (rst)
    dram_re |=> (dram_we && !alu_en));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dram_re && dram_we));
  // R9
  jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> ##2 (imem_rd && imem_addr == $past(jmp_tgt, 2)));
endmodule

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] imem_addr;
  logic        imem_rd;
  logic [15:0] imem_data = '0;
  logic [7:0]  w_q = '0;
  logic        alu_en, alu_add;
  logic [7:0]  alu_k;
  logic [11:0] dram_addr;
  logic        dram_re, dram_we;
  logic [7:0]  dram_wdata;
  logic [7:0]  dram_rdata = '0;

  always #10 clk = ~clk;

  fetch_seq u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
    .imem_data(imem_data), .w_in(w_q), .alu_en(alu_en), .alu_add(alu_add),
    .alu_k(alu_k), .dram_addr(dram_addr), .dram_re(dram_re), .dram_we(dram_we),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

  logic [7:0] rom [0:4095];
  logic [7:0] ram [0:4095];
  logic [7:0] rm  [0:4095];

  logic [20:0] fq[$];  string ft[$];
  logic [8:0]  aq[$];  string at[$];
  logic [20:0] dq[$];  string dt[$];

  int n_chk = 0, n_bad = 0;
  logic [20:0] pa = '0;
  logic [7:0]  wm = '0;
  string       nxt_tag = "R1";
  logic        prev_re = 1'b0;

  // bench models of the memories and the ALU
  always @(posedge clk) begin
    if (imem_rd) imem_data <= {rom[imem_addr[11:0] + 12'd1], rom[imem_addr[11:0]]};
    if (dram_re) dram_rdata <= ram[dram_addr];
    if (dram_we) ram[dram_addr] <= dram_wdata;
    if (alu_en)  w_q <= alu_add ? (w_q + alu_k) : alu_k;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic emit(input logic [15:0] wd, input string tag);
    rom[pa[11:0]]         = wd[7:0];
    rom[pa[11:0] + 12'd1] = wd[15:8];
    fq.push_back(pa);
    ft.push_back(nxt_tag != "" ? nxt_tag : tag);
    nxt_tag = "";
    pa = pa + 21'd2;
  endtask

  task automatic p_movl(input logic [7:0] k, input string tag);
    emit({8'h0E, k}, "R2");
    aq.push_back({1'b0, k}); at.push_back(tag);
    wm = k;
  endtask

  task automatic p_addl(input logic [7:0] k);
    emit({8'h0F, k}, "R2");
    aq.push_back({1'b1, k}); at.push_back("R4");
    wm = wm + k;
  endtask

  task automatic p_stw(input logic [7:0] f);
    logic [11:0] a;
    a = (f >= 8'h80) ? (12'hF00 + {4'h0, f}) : {4'h0, f};
    emit({8'h6E, f}, "R2");
    dq.push_back({1'b1, a, wm}); dt.push_back(f >= 8'h80 ? "R6" : "R5");
    rm[a] = wm;
  endtask

  task automatic p_cpy(input logic [11:0] s, input logic [11:0] d);
    emit({4'hC, s}, "R2");
    emit({4'hF, d}, "R2");
    dq.push_back({1'b0, s, 8'h00}); dt.push_back("R8");
    dq.push_back({1'b1, d, rm[s]}); dt.push_back("R8");
    rm[d] = rm[s];
  endtask

  task automatic p_jmp(input logic [19:0] tw);
    emit({8'hEF, tw[7:0]}, "R2");
    emit({4'hF, tw[19:8]}, "R2");
    pa = {tw, 1'b0};
    nxt_tag = "R9";
  endtask

  // monitor: sample registered outputs away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      chk(!imem_rd && !alu_en && !dram_re && !dram_we, "R1",
          {28'd0, imem_rd, alu_en, dram_re, dram_we}, 32'd0);
    end else begin
      if (imem_rd && fq.size() > 0) begin
        chk(imem_addr == fq[0], ft[0], {11'd0, imem_addr}, {11'd0, fq[0]});
        void'(fq.pop_front()); void'(ft.pop_front());
      end
      if (alu_en) begin
        if (aq.size() == 0) chk(1'b0, "R7/R12 stray alu_en", {23'd0, alu_add, alu_k}, 32'd0);
        else begin
          chk({alu_add, alu_k} == aq[0], at[0], {23'd0, alu_add, alu_k}, {23'd0, aq[0]});
          void'(aq.pop_front()); void'(at.pop_front());
        end
      end
      if (dram_re || dram_we) begin
        if (dq.size() == 0) chk(1'b0, "R7/R12 stray dram", {19'd0, dram_addr, dram_we}, 32'd0);
        else begin
          if (dram_we)
            chk(dram_we == dq[0][20] && dram_addr == dq[0][19:8] && dram_wdata == dq[0][7:0],
                dt[0], {11'd0, dram_we, dram_addr, dram_wdata}, {11'd0, dq[0]});
          else
            chk(!dq[0][20] && dram_addr == dq[0][19:8], dt[0],
                {11'd0, dram_we, dram_addr, 8'h00}, {11'd0, dq[0]});
          void'(dq.pop_front()); void'(dt.pop_front());
        end
      end
      if (prev_re) chk(dram_we == 1'b1, "R8 write follows read", {31'd0, dram_we}, 32'd1);
      prev_re <= dram_re;
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4096; i++) begin
      rom[i] = 8'h00;
      ram[i] = i[7:0] ^ 8'h5A;
      rm[i]  = i[7:0] ^ 8'h5A;
    end
    // program: literals and stores over every file address
    p_movl(8'h3C, "R3");
    for (int f = 0; f < 256; f++) begin
      if (f % 2 == 1) p_addl(8'(f * 3));
      else            p_movl(8'(f) ^ 8'hA5, "R3");
      p_stw(8'(f));
    end
    emit(16'h6F40, "R7"); emit(16'h6F90, "R7");
    emit(16'h0000, "R12"); emit(16'h1234, "R12"); emit(16'hE5AA, "R12");
    emit(16'hD123, "R12"); emit(16'h6D55, "R12");
    emit(16'hF123, "R10"); emit(16'hFFFF, "R10");
    emit(16'hC012, "R11"); p_movl(8'h77, "R11");
    emit(16'hEF10, "R11"); p_stw(8'h20);
    for (int i = 0; i < 32; i++) begin
      logic [11:0] s, d;
      s = (i % 4 == 0) ? (12'hF80 + 12'(i * 3)) : 12'(i * 37);
      d = (i % 3 == 0) ? (12'hFA0 + 12'(i)) : (12'h100 + 12'(i * 5));
      if (i == 5) d = s;
      p_cpy(s, d);
      if (i % 8 == 7) p_cpy(d, 12'h300 + 12'(i));
    end
    p_jmp(pa[20:1] + 20'd12);
    p_movl(8'h11, "R3");
    p_jmp(20'hD5F00);
    p_movl(8'hC3, "R3");
    p_stw(8'hFF);
    p_cpy(12'hFFF, 12'h000);
    p_jmp(20'h00300);
    p_movl(8'h01, "R3");
    p_addl(8'hFF);
    p_stw(8'h7F);
    p_jmp(pa[20:1]);

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc = 0;
    while ((fq.size() > 0 || aq.size() > 0 || dq.size() > 0) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 100000) chk(1'b0, "watchdog", cyc, 0);
    repeat (20) @(posedge clk);
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule